// File: doc/BRIEF.md
# Indexed-Access Prioritized Interrupt Controller

This block gathers a parameterized set of system interrupt lines (64 by default). Each line is assigned one of four trigger modes: active-high level, active-low level, rising edge or falling edge. Each line is captured into a status bit. A pending line is one whose status bit and enable bit are both set. The controller finds the highest-priority pending line and reports its number through a prioritized-index register. It raises a single host interrupt request while a line is pending and both the host enable and the global enable are on.

Software reaches the block over a simple 32-bit register port with a one-cycle write strobe and a one-cycle read strobe. To change one enable bit or one status bit, software writes that line's number to an indexed set or clear register. To change many bits at once, it writes a mask to the write-one-to-clear bitmap banks. Each line also has a byte-wide channel number in the channel-map banks. The channel number sets the line's priority.

Top module: `indexed_intc`

## Requirements
- R1: After reset the line enables, global enable and host enable are 0. Every channel byte is 0x07. Every polarity bit is 1 and every type bit is 0. The host request is low, and a read of the prioritized index (0x080) returns 0x80000000.
- R2: Line i is configured by bit i%32 of polarity word i/32 (base 0x0D00) and of type word i/32 (base 0x0D80). The {type,polarity} encodings are: 11 rising edge, 10 falling edge, 01 active-high level, 00 active-low level. A qualifying input change shows in the status two rising clock edges after it is applied.
- R3: In level mode the status bit follows the qualified level. A clear written while the level is still active leaves the bit set. The bit drops once the level goes inactive.
- R4: In edge mode the status bit stays set until it is cleared. It is cleared by writing the line number to 0x024, or by writing 1 to its bit in status bitmap word i/32 (base 0x0280, where writing 0 has no effect). If an edge and a clear land in the same cycle, the edge wins. Reading status bitmap word w returns the status bits of lines 32w to 32w+31.
- R5: Writing a line number to 0x028 sets that line's enable, and writing it to 0x02C clears it. Writing 1 to a bit of enable bitmap word i/32 (base 0x0380) clears that enable, and writing 0 has no effect. A line number of NUM_IRQ or above is ignored. Reading the enable bitmap word returns the enable bits.
- R6: The host enable is set by writing 0 to 0x034 and cleared by writing 0 to 0x038. Any other number written to these two registers is ignored. The host enable is also bit 0 of 0x1500, which can be read and written. While the host enable is 0, the host request is low.
- R7: Bit 0 of 0x010 is the global enable. While it is 0, the host request is low.
- R8: The host request is high in the same cycle that the global enable, the host enable and at least one pending line are all present together.
- R9: A read of 0x080 returns the winning line number in bits 9:0 and sets bit 31 when no line is pending. The lowest channel byte wins. Among lines with equal channel bytes, the lowest line number wins.
- R10: Channel-map word w (base 0x0400) holds the channel bytes of lines 4w to 4w+3, with line i in byte lane i%4. The words can be read and written.
- R11: Read data is registered and appears in the cycle after the read strobe. Writes to 0x004 and 0x00C are accepted with no effect, and those addresses read as 0. Any unmapped address also reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_i | input | NUM_IRQ | System interrupt lines |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 13 | Byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid one cycle after the read strobe |
| host_irq_o | output | 1 | Host interrupt request, active high |

## Verification
The risky overlap is an edge-mode line that detects its edge in the same cycle that software clears its status bit. The bench provokes this by raising the line at one falling clock edge and then timing the index-clear write so that its strobe covers the rising edge at which the edge is captured. It then reads back the status bitmap and expects the bit to still be set. A second overlap is a level-mode line cleared while its level is still active. The bench checks this by reading the status back afterwards and expecting the bit to still be set.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int ADDR_W = 13;

    // Single registers
    localparam logic [ADDR_W-1:0] A_CTRL     = 13'h004;
    localparam logic [ADDR_W-1:0] A_HCTRL    = 13'h00C;
    localparam logic [ADDR_W-1:0] A_GLOBAL   = 13'h010;
    localparam logic [ADDR_W-1:0] A_ST_ICLR  = 13'h024;
    localparam logic [ADDR_W-1:0] A_EN_ISET  = 13'h028;
    localparam logic [ADDR_W-1:0] A_EN_ICLR  = 13'h02C;
    localparam logic [ADDR_W-1:0] A_HO_ISET  = 13'h034;
    localparam logic [ADDR_W-1:0] A_HO_ICLR  = 13'h038;
    localparam logic [ADDR_W-1:0] A_WINNER   = 13'h080;
    localparam logic [ADDR_W-1:0] A_HO_MAP   = 13'h1500;

    // Bank bases
    localparam logic [ADDR_W-1:0] B_ST_CLR   = 13'h0280;
    localparam logic [ADDR_W-1:0] B_EN_CLR   = 13'h0380;
    localparam logic [ADDR_W-1:0] B_CHAN     = 13'h0400;
    localparam logic [ADDR_W-1:0] B_POL      = 13'h0D00;
    localparam logic [ADDR_W-1:0] B_TYPE     = 13'h0D80;

    localparam int CHAN_W    = 8;
    localparam int WIN_IDX_W = 10;

    // {type, polarity}
    typedef enum logic [1:0] {
        TRIG_LVL_LO    = 2'b00,
        TRIG_LVL_HI    = 2'b01,
        TRIG_EDGE_FALL = 2'b10,
        TRIG_EDGE_RISE = 2'b11
    } trig_e;

    function automatic logic in_bank(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] base,
                                     input int nwords);
        return (int'(a) >= int'(base)) && (int'(a) < int'(base) + 4 * nwords);
    endfunction

    function automatic int bank_word(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] base);
        return (int'(a) - int'(base)) >>> 2;
    endfunction

endpackage

// File: rtl/intc_sense.sv
module intc_sense
    import intc_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_IRQ-1:0] irq_i,
    input  logic [NUM_IRQ-1:0] pol_i,
    input  logic [NUM_IRQ-1:0] typ_i,
    output logic [NUM_IRQ-1:0] act_o,
    output logic [NUM_IRQ-1:0] edge_o
);

    typedef struct packed {
        logic [NUM_IRQ-1:0] smp;
        logic [NUM_IRQ-1:0] dly;
    } sense_t;

    sense_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.smp = irq_i;
        s_d.dly = s_q.smp;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
        trig_e mode;
        logic  rise, fall;
        assign mode      = trig_e'({typ_i[g], pol_i[g]});
        assign rise      = s_q.smp[g] & ~s_q.dly[g];
        assign fall      = ~s_q.smp[g] & s_q.dly[g];
        assign edge_o[g] = ((mode == TRIG_EDGE_RISE) && rise) ||
                           ((mode == TRIG_EDGE_FALL) && fall);
        assign act_o[g]  = ((mode == TRIG_LVL_HI) &&  s_q.smp[g]) ||
                           ((mode == TRIG_LVL_LO) && !s_q.smp[g]);
    end

endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
    import intc_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic [NUM_IRQ-1:0]        pend_i,
    input  logic [CHAN_W*NUM_IRQ-1:0] chan_i,
    output logic                      valid_o,
    output logic [WIN_IDX_W-1:0]      idx_o
);

    logic              found;
    logic [CHAN_W-1:0] best;

    always_comb begin
        found = 1'b0;
        best  = '1;
        idx_o = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (pend_i[i] && (!found || chan_i[CHAN_W*i +: CHAN_W] < best)) begin
                found = 1'b1;
                best  = chan_i[CHAN_W*i +: CHAN_W];
                idx_o = WIN_IDX_W'(i);
            end
        end
        valid_o = found;
    end

endmodule

// File: rtl/indexed_intc.sv
module indexed_intc
    import intc_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_IRQ-1:0] irq_i,
    input  logic               reg_wr_i,
    input  logic               reg_rd_i,
    input  logic [12:0]        reg_addr_i,
    input  logic [31:0]        reg_wdata_i,
    output logic [31:0]        reg_rdata_o,
    output logic               host_irq_o
);

    localparam int BM_WORDS = NUM_IRQ / 32;
    localparam int CM_WORDS = NUM_IRQ / 4;

    typedef struct packed {
        logic [NUM_IRQ-1:0]        stat;
        logic [NUM_IRQ-1:0]        en;
        logic [NUM_IRQ-1:0]        pol;
        logic [NUM_IRQ-1:0]        typ;
        logic [CHAN_W*NUM_IRQ-1:0] chan;
        logic                      gen;
        logic                      hen;
        logic [31:0]               rdata;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_IRQ-1:0]   lvl_act, edge_hit, stat_clr, en_set, en_clr;
    logic                 win_valid;
    logic [WIN_IDX_W-1:0] win_idx;
    logic                 gen_q, hen_q;
    logic [NUM_IRQ-1:0]   pend_q, en_q;
    int                   w_st, w_en, w_cm, w_pl, w_ty;

    intc_sense #(.NUM_IRQ(NUM_IRQ)) u_sense (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .irq_i  (irq_i),
        .pol_i  (st_q.pol),
        .typ_i  (st_q.typ),
        .act_o  (lvl_act),
        .edge_o (edge_hit)
    );

    assign pend_q = st_q.stat & st_q.en;
    assign en_q   = st_q.en;
    assign gen_q  = st_q.gen;
    assign hen_q  = st_q.hen;

    intc_arbiter #(.NUM_IRQ(NUM_IRQ)) u_arb (
        .pend_i  (pend_q),
        .chan_i  (st_q.chan),
        .valid_o (win_valid),
        .idx_o   (win_idx)
    );

    always_comb begin
        st_d = st_q;
        w_st = bank_word(reg_addr_i, B_ST_CLR);
        w_en = bank_word(reg_addr_i, B_EN_CLR);
        w_cm = bank_word(reg_addr_i, B_CHAN);
        w_pl = bank_word(reg_addr_i, B_POL);
        w_ty = bank_word(reg_addr_i, B_TYPE);

        // Per-line status and enable
        for (int i = 0; i < NUM_IRQ; i++) begin
            stat_clr[i] = reg_wr_i &&
                ((reg_addr_i == A_ST_ICLR && reg_wdata_i == 32'(i)) ||
                 (in_bank(reg_addr_i, B_ST_CLR, BM_WORDS) && w_st == i / 32 &&
                  reg_wdata_i[i % 32]));
            en_set[i]   = reg_wr_i && reg_addr_i == A_EN_ISET && reg_wdata_i == 32'(i);
            en_clr[i]   = reg_wr_i &&
                ((reg_addr_i == A_EN_ICLR && reg_wdata_i == 32'(i)) ||
                 (in_bank(reg_addr_i, B_EN_CLR, BM_WORDS) && w_en == i / 32 &&
                  reg_wdata_i[i % 32]));

            if (st_q.typ[i]) st_d.stat[i] = (st_q.stat[i] && !stat_clr[i]) || edge_hit[i];
            else             st_d.stat[i] = lvl_act[i];

            if (en_set[i])      st_d.en[i] = 1'b1;
            else if (en_clr[i]) st_d.en[i] = 1'b0;
        end

        // Configuration banks
        if (reg_wr_i) begin
            for (int w = 0; w < BM_WORDS; w++) begin
                if (in_bank(reg_addr_i, B_POL, BM_WORDS) && w_pl == w)
                    st_d.pol[32*w +: 32] = reg_wdata_i;
                if (in_bank(reg_addr_i, B_TYPE, BM_WORDS) && w_ty == w)
                    st_d.typ[32*w +: 32] = reg_wdata_i;
            end
            for (int w = 0; w < CM_WORDS; w++) begin
                if (in_bank(reg_addr_i, B_CHAN, CM_WORDS) && w_cm == w)
                    st_d.chan[32*w +: 32] = reg_wdata_i;
            end
            if (reg_addr_i == A_GLOBAL) st_d.gen = reg_wdata_i[0];
            if (reg_addr_i == A_HO_MAP) st_d.hen = reg_wdata_i[0];
            if (reg_addr_i == A_HO_ISET && reg_wdata_i == 32'd0) st_d.hen = 1'b1;
            if (reg_addr_i == A_HO_ICLR && reg_wdata_i == 32'd0) st_d.hen = 1'b0;
        end

        // Registered read path
        if (reg_rd_i) begin
            st_d.rdata = '0;
            if (reg_addr_i == A_WINNER)
                st_d.rdata = {~win_valid, {(31-WIN_IDX_W){1'b0}}, win_idx};
            if (reg_addr_i == A_GLOBAL) st_d.rdata = {31'd0, st_q.gen};
            if (reg_addr_i == A_HO_MAP) st_d.rdata = {31'd0, st_q.hen};
            for (int w = 0; w < BM_WORDS; w++) begin
                if (in_bank(reg_addr_i, B_ST_CLR, BM_WORDS) && w_st == w)
                    st_d.rdata = st_q.stat[32*w +: 32];
                if (in_bank(reg_addr_i, B_EN_CLR, BM_WORDS) && w_en == w)
                    st_d.rdata = st_q.en[32*w +: 32];
                if (in_bank(reg_addr_i, B_POL, BM_WORDS) && w_pl == w)
                    st_d.rdata = st_q.pol[32*w +: 32];
                if (in_bank(reg_addr_i, B_TYPE, BM_WORDS) && w_ty == w)
                    st_d.rdata = st_q.typ[32*w +: 32];
            end
            for (int w = 0; w < CM_WORDS; w++) begin
                if (in_bank(reg_addr_i, B_CHAN, CM_WORDS) && w_cm == w)
                    st_d.rdata = st_q.chan[32*w +: 32];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.stat  <= '0;
            st_q.en    <= '0;
            st_q.pol   <= '1;
            st_q.typ   <= '0;
            st_q.chan  <= {NUM_IRQ{8'h07}};
            st_q.gen   <= 1'b0;
            st_q.hen   <= 1'b0;
            st_q.rdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_rdata_o = st_q.rdata;
    assign host_irq_o  = st_q.gen & st_q.hen & (|pend_q);

endmodule

// File: rtl/intc_checker.sv
module intc_checker
    import intc_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 reg_wr_i,
    input logic                 reg_rd_i,
    input logic [12:0]          reg_addr_i,
    input logic [31:0]          reg_wdata_i,
    input logic [31:0]          reg_rdata_o,
    input logic                 host_irq_o,
    input logic                 gen_q,
    input logic                 hen_q,
    input logic [NUM_IRQ-1:0]   pend_q,
    input logic [NUM_IRQ-1:0]   en_q,
    input logic                 win_valid,
    input logic [WIN_IDX_W-1:0] win_idx
);

    localparam int IW = $clog2(NUM_IRQ);

    AST_GLOBAL_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !gen_q |-> !host_irq_o); // R7

    AST_HOST_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !hen_q |-> !host_irq_o); // R6

    AST_IRQ_TRACKS_WINNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gen_q && hen_q) |-> (host_irq_o == win_valid)); // R8

    AST_WINNER_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
        win_valid |-> (int'(win_idx) < NUM_IRQ && pend_q[win_idx[IW-1:0]])); // R9

    AST_NONE_MEANS_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !win_valid |-> (pend_q == '0)); // R9

    AST_WINNER_FLAG_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_rd_i && reg_addr_i == A_WINNER) |=> (reg_rdata_o[31] == !$past(win_valid))); // R9

    AST_ENABLE_INDEX_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_wr_i && reg_addr_i == A_EN_ISET && reg_wdata_i < 32'(NUM_IRQ))
        |=> en_q[$past(reg_wdata_i[IW-1:0])]); // R5

endmodule

bind indexed_intc intc_checker #(.NUM_IRQ(NUM_IRQ)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_wr_i    (reg_wr_i),
    .reg_rd_i    (reg_rd_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .host_irq_o  (host_irq_o),
    .gen_q       (gen_q),
    .hen_q       (hen_q),
    .pend_q      (pend_q),
    .en_q        (en_q),
    .win_valid   (win_valid),
    .win_idx     (win_idx)
);

// File: tb/sim_indexed_intc.sv
module sim_indexed_intc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [12:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        host_irq;

    int n_chk = 0;
    int n_err = 0;
    logic [255:0] cm_model;

    always #10 clk = ~clk;

    indexed_intc #(.NUM_IRQ(64)) u0 (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .irq_i       (irq),
        .reg_wr_i    (wr),
        .reg_rd_i    (rd),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .host_irq_o  (host_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [12:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [12:0] a, output logic [31:0] d);
        @(negedge clk);
        rd = 1'b1; addr = a;
        @(posedge clk);
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic expect_reg(input string req, input logic [12:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd_reg(a, v);
        check(req, v, exp);
    endtask

    task automatic settle();
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] exp_winner(input logic [31:0] pend, input logic [255:0] cm);
        logic       found = 1'b0;
        logic [7:0] best  = 8'hFF;
        logic [31:0] r    = 32'h8000_0000;
        for (int i = 0; i < 32; i++) begin
            if (pend[i] && (!found || cm[8*i +: 8] < best)) begin
                found = 1'b1;
                best  = cm[8*i +: 8];
                r     = 32'(i);
            end
        end
        return r;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=%08h expected=%08h", 32'd1, 32'd0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 host_irq", {31'd0, host_irq}, 32'd0);
        expect_reg("R1 winner", 13'h080, 32'h8000_0000);
        expect_reg("R1 chan map", 13'h400, 32'h0707_0707);
        expect_reg("R1 polarity", 13'hD00, 32'hFFFF_FFFF);
        expect_reg("R1 type", 13'hD80, 32'h0);
        expect_reg("R1 enable", 13'h380, 32'h0);

        // R11 control writes and unmapped reads
        wr_reg(13'h004, 32'h0);
        expect_reg("R11 ctrl reads 0", 13'h004, 32'h0);
        expect_reg("R11 unmapped", 13'h1FC, 32'h0);

        // R5 enables
        wr_reg(13'h028, 32'd5);
        expect_reg("R5 index set", 13'h380, 32'h20);
        wr_reg(13'h028, 32'd100);
        expect_reg("R5 out of range low", 13'h380, 32'h20);
        expect_reg("R5 out of range high", 13'h384, 32'h0);
        wr_reg(13'h380, 32'h0);
        expect_reg("R5 zero mask no effect", 13'h380, 32'h20);
        wr_reg(13'h02C, 32'd5);
        expect_reg("R5 index clear", 13'h380, 32'h0);
        wr_reg(13'h028, 32'd37);
        expect_reg("R5 upper word set", 13'h384, 32'h20);
        wr_reg(13'h384, 32'h20);
        expect_reg("R5 bitmap clear", 13'h384, 32'h0);

        // R3 R6 R7 R8 level line 3
        @(negedge clk); irq[3] = 1'b1;
        settle();
        expect_reg("R3 level status", 13'h280, 32'h8);
        wr_reg(13'h028, 32'd3);
        check("R7 global off", {31'd0, host_irq}, 32'd0);
        expect_reg("R9 winner w/o global", 13'h080, 32'd3);
        wr_reg(13'h010, 32'd1);
        check("R6 host off", {31'd0, host_irq}, 32'd0);
        wr_reg(13'h034, 32'd0);
        check("R8 request up", {31'd0, host_irq}, 32'd1);
        wr_reg(13'h1500, 32'd0);
        check("R6 bitmap clear", {31'd0, host_irq}, 32'd0);
        expect_reg("R6 bitmap read", 13'h1500, 32'd0);
        wr_reg(13'h034, 32'd5);
        check("R6 other host ignored", {31'd0, host_irq}, 32'd0);
        wr_reg(13'h1500, 32'd1);
        check("R6 bitmap set", {31'd0, host_irq}, 32'd1);
        wr_reg(13'h010, 32'd0);
        check("R7 global gate", {31'd0, host_irq}, 32'd0);
        wr_reg(13'h010, 32'd1);
        wr_reg(13'h024, 32'd3);
        expect_reg("R3 clear while active", 13'h280, 32'h8);
        @(negedge clk); irq[3] = 1'b0;
        settle();
        expect_reg("R3 level drop", 13'h280, 32'h0);
        check("R8 request down", {31'd0, host_irq}, 32'd0);
        expect_reg("R9 none pending", 13'h080, 32'h8000_0000);

        // R2 R4 edge modes on lines 40..42
        wr_reg(13'hD84, 32'h100);
        @(negedge clk); irq[40] = 1'b1;
        @(negedge clk); irq[40] = 1'b0;
        settle();
        expect_reg("R2 rising edge", 13'h284, 32'h100);
        expect_reg("R4 sticky", 13'h284, 32'h100);
        wr_reg(13'h024, 32'd40);
        expect_reg("R4 index clear", 13'h284, 32'h0);
        // edge and clear in the same cycle
        @(negedge clk); irq[40] = 1'b1;
        @(posedge clk);
        @(negedge clk); wr = 1'b1; addr = 13'h024; wdata = 32'd40;
        @(posedge clk);
        @(negedge clk); wr = 1'b0;
        expect_reg("R4 edge beats clear", 13'h284, 32'h100);
        wr_reg(13'h284, 32'h100);
        expect_reg("R4 bitmap clear", 13'h284, 32'h0);
        @(negedge clk); irq[40] = 1'b0;
        settle();
        wr_reg(13'hD84, 32'h300);
        wr_reg(13'hD04, 32'hFFFF_FDFF);
        @(negedge clk); irq[41] = 1'b1;
        settle();
        expect_reg("R2 falling ignores rise", 13'h284, 32'h0);
        @(negedge clk); irq[41] = 1'b0;
        settle();
        expect_reg("R2 falling edge", 13'h284, 32'h200);
        wr_reg(13'hD04, 32'hFFFF_F9FF);
        settle();
        expect_reg("R2 active-low level", 13'h284, 32'h600);
        @(negedge clk); irq[42] = 1'b1;
        settle();
        expect_reg("R2 active-low released", 13'h284, 32'h200);
        @(negedge clk); irq[42] = 1'b0;
        wr_reg(13'hD04, 32'hFFFF_FFFF);
        wr_reg(13'hD84, 32'h0);
        settle();
        expect_reg("R2 restored", 13'h284, 32'h0);

        // R9 R10 directed priority
        wr_reg(13'h408, 32'h0702_0707);
        wr_reg(13'h414, 32'h0707_0702);
        wr_reg(13'h41C, 32'h0703_0707);
        expect_reg("R10 chan readback", 13'h408, 32'h0702_0707);
        wr_reg(13'h028, 32'd10);
        wr_reg(13'h028, 32'd20);
        wr_reg(13'h028, 32'd30);
        @(negedge clk); irq[10] = 1'b1; irq[20] = 1'b1; irq[30] = 1'b1;
        settle();
        expect_reg("R9 tie lowest number", 13'h080, 32'd10);
        wr_reg(13'h02C, 32'd10);
        expect_reg("R9 next in channel", 13'h080, 32'd20);
        wr_reg(13'h41C, 32'h0701_0707);
        expect_reg("R9 R10 lower channel wins", 13'h080, 32'd30);

        // R9 R8 random
        for (int t = 0; t < 24; t++) begin
            logic [31:0] pat, msk;
            pat = $urandom;
            msk = $urandom;
            if (t % 3 == 0) msk = msk & $urandom;
            if (t == 5) msk = 32'h0;
            wr_reg(13'h380, 32'hFFFF_FFFF);
            for (int w = 0; w < 8; w++) begin
                logic [31:0] v;
                v = {5'd0, 3'($urandom), 5'd0, 3'($urandom), 5'd0, 3'($urandom), 5'd0, 3'($urandom)};
                cm_model[32*w +: 32] = v;
                wr_reg(13'(13'h400 + 4 * w), v);
            end
            for (int i = 0; i < 32; i++)
                if (msk[i]) wr_reg(13'h028, 32'(i));
            @(negedge clk); irq[31:0] = pat;
            settle();
            expect_reg("R9 random winner", 13'h080, exp_winner(pat & msk, cm_model));
            check("R8 random request", {31'd0, host_irq}, {31'd0, |(pat & msk)});
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule